// File: doc/BRIEF.md
# Multi-channel compare-match timer

A memory-mapped timer with four independent channels. Each channel holds an up-counter, a compare register and a 16-bit control/status word. One shared start register holds a run bit for every channel. A running channel divides a slow reference pulse by a selectable ratio and counts the divided ticks. When the count equals the compare value, the channel raises a match flag. That flag can drive the channel's interrupt line. In periodic mode the match also returns the counter to zero. In free-running mode the counter runs on and reports an overflow when it wraps.

The reference clock reaches the block as a one-cycle pulse `refPulse` in the system clock domain. Software writes to a counter are held in a staging register and reach the counter only on the second reference pulse that follows the write. During that window a status bit reports the write as pending. Software uses the block as a periodic tick source or as a one-shot event timer. Each flag is cleared by writing it back as zero.

Top module: `match_timer`

## Requirements
- R1: After reset the start register reads 0, every counter reads 0, every compare register reads 0xFFFFFFFF, every control/status word reads 0 and all `irq` bits are low.
- R2: Byte address 0x00 is the start register. Bit n runs channel n. A write stores bits [3:0] and leaves each channel's counting independent of the other channels. Bits above 3 read as zero.
- R3: Channel n's registers start at 0x10+n*0x10: control/status at +0, counter at +4, compare at +8. In the control/status word, clock select is bits [2:0]. Code 4 advances the counter once per 8 reference pulses, code 5 once per 32, code 6 once per 128, and every other code once per pulse.
- R4: Bit 15 (match flag) sets on the divided tick where the counter equals the compare value. `irq[n]` is high exactly while bit 15 is 1 and bits [5:4] equal 2.
- R5: With bit 8 (periodic) set, a match returns the counter to zero, so one period spans compare+1 ticks.
- R6: With bit 8 clear, the counter passes the compare value. A tick at 0xFFFFFFFF wraps it to 0, sets bit 14 (overflow), and counting continues.
- R7: A control/status write clears bit 15 or bit 14 when that bit is written 0, and keeps it when written 1. Bits 9, 8, 7, [5:4] and [2:0] take the written value.
- R8: A flag-set event in the same cycle as a control/status write that writes the flag as 0 leaves the flag at 1.
- R9: While a channel's start bit is 0, its prescaler and counter hold their values and its flags do not set.
- R10: A counter write becomes visible to reads and to counting on the second reference pulse after it. Until then the counter reads the old value and bit 13 reads 1. This holds whether or not the channel runs.
- R11: A 32-bit access at +4 or +8 moves the full register. A 16-bit access at +4 or +8 moves the low half, and one at +6 or +0xA moves the high half. The half travels on data bits [15:0].
- R12: Writing 0 to a channel's control/status word drops its `irq` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | One-cycle pulse per reference clock period |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 for write, 0 for read |
| busWide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data (16-bit accesses use bits 15:0) |
| busRdata | output | 32 | Read data, combinational from the address |
| irq | output | 4 | Per-channel interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software flag clear and a hardware match. The bench sets periodic mode with compare zero, so that every reference pulse matches. It then issues the clear write in the very cycle that carries a reference pulse. It expects the flag to read 1 afterwards, and a later clear with no pulse must drop it. The second pair is a staged counter write landing on a running channel. Here the bench expects the staged value to win over the tick that would have counted in that cycle.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = 16;
  localparam int PRE_W  = 7;

  // control/status bit positions
  localparam int B_CMF = 15;
  localparam int B_OVF = 14;
  localparam int B_WIP = 13;
  localparam int B_CMS = 9;
  localparam int B_PRD = 8;
  localparam int B_OIE = 7;
  localparam logic [1:0] REQ_IRQ = 2'd2;

  // write strobes from the register decode to one channel
  typedef struct packed {
    logic csrWr;
    logic cntLo;
    logic cntHi;
    logic cmpLo;
    logic cmpHi;
  } chanStrb_t;

  // last prescaler state for a clock-select code
  function automatic logic [PRE_W-1:0] divLast(input logic [2:0] sel);
    case (sel)
      3'd4:    return PRE_W'(7);
      3'd5:    return PRE_W'(31);
      3'd6:    return PRE_W'(127);
      default: return PRE_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale import mt_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPulse,
  input  logic       run,
  input  logic [2:0] clkSel,
  output logic       tick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] lastVal;
  logic             wrapNow;

  assign lastVal = divLast(clkSel);
  assign wrapNow = (preCnt >= lastVal);
  assign tick    = run & refPulse & wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (run && refPulse) begin
      preCnt <= wrapNow ? '0 : preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mt_chan.sv
module mt_chan import mt_pkg::*; #(
  parameter int SYNC_REFS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              run,
  input  chanStrb_t         strb,
  input  logic [CNT_W-1:0]  wdata,
  output logic [HALF_W-1:0] csrRd,
  output logic [CNT_W-1:0]  cntRd,
  output logic [CNT_W-1:0]  cmpRd,
  output logic              irq
);
  localparam int AGE_W = (SYNC_REFS > 1) ? $clog2(SYNC_REFS) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(SYNC_REFS - 1);

  logic             flagCm, flagOv, selCm, modePrd, outEn;
  logic [1:0]       reqType;
  logic [2:0]       clkSel;
  logic [CNT_W-1:0] cnt, cmp, pendVal, pendBase, pendNext;
  logic             pendOn;
  logic [AGE_W-1:0] pendAge;
  logic             tick, applyPend, hit, atMax, cmSet, ovSet, cntWrAny;

  mt_prescale u_pre (
    .clk      (clk),
    .rstN     (rstN),
    .refPulse (refPulse),
    .run      (run),
    .clkSel   (clkSel),
    .tick     (tick)
  );

  assign applyPend = pendOn & refPulse & (pendAge == AGE_LAST);
  assign hit       = (cnt == cmp);
  assign atMax     = &cnt;
  assign cmSet     = tick & ~applyPend & hit;
  assign ovSet     = tick & ~applyPend & ~modePrd & atMax;
  assign cntWrAny  = strb.cntLo | strb.cntHi;
  assign pendBase  = pendOn ? pendVal : cnt;

  always_comb begin
    pendNext = pendBase;
    if (strb.cntLo) pendNext[HALF_W-1:0]     = wdata[HALF_W-1:0];
    if (strb.cntHi) pendNext[CNT_W-1:HALF_W] = wdata[CNT_W-1:HALF_W];
  end

  // counter: staged write wins over a tick in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (applyPend) begin
      cnt <= pendVal;
    end else if (tick) begin
      cnt <= (hit && modePrd) ? '0 : cnt + 1'b1;
    end
  end

  // staging of counter writes across reference pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVal <= '0;
      pendOn  <= 1'b0;
      pendAge <= '0;
    end else if (cntWrAny) begin
      pendVal <= pendNext;
      pendOn  <= 1'b1;
      pendAge <= '0;
    end else if (pendOn && refPulse) begin
      if (pendAge == AGE_LAST) pendOn <= 1'b0;
      else                     pendAge <= pendAge + 1'b1;
    end
  end

  // compare register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp <= '1;
    end else begin
      if (strb.cmpLo) cmp[HALF_W-1:0]     <= wdata[HALF_W-1:0];
      if (strb.cmpHi) cmp[CNT_W-1:HALF_W] <= wdata[CNT_W-1:HALF_W];
    end
  end

  // control/status: flags set by hardware, cleared by writing zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagCm  <= 1'b0;
      flagOv  <= 1'b0;
      selCm   <= 1'b0;
      modePrd <= 1'b0;
      outEn   <= 1'b0;
      reqType <= 2'd0;
      clkSel  <= 3'd0;
    end else if (strb.csrWr) begin
      flagCm  <= cmSet | (flagCm & wdata[B_CMF]);
      flagOv  <= ovSet | (flagOv & wdata[B_OVF]);
      selCm   <= wdata[B_CMS];
      modePrd <= wdata[B_PRD];
      outEn   <= wdata[B_OIE];
      reqType <= wdata[5:4];
      clkSel  <= wdata[2:0];
    end else begin
      flagCm  <= flagCm | cmSet;
      flagOv  <= flagOv | ovSet;
    end
  end

  always_comb begin
    csrRd        = '0;
    csrRd[B_CMF] = flagCm;
    csrRd[B_OVF] = flagOv;
    csrRd[B_WIP] = pendOn;
    csrRd[B_CMS] = selCm;
    csrRd[B_PRD] = modePrd;
    csrRd[B_OIE] = outEn;
    csrRd[5:4]   = reqType;
    csrRd[2:0]   = clkSel;
  end

  assign cntRd = cnt;
  assign cmpRd = cmp;
  assign irq   = flagCm & (reqType == REQ_IRQ);
endmodule

// File: rtl/mt_regif.sv
module mt_regif import mt_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busSel,
  input  logic                           busWr,
  input  logic                           busWide,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [CNT_W-1:0]               busWdata,
  input  logic [NUM_CH-1:0][HALF_W-1:0]  csrRd,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cntRd,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cmpRd,
  output chanStrb_t [NUM_CH-1:0]         strb,
  output logic [CNT_W-1:0]               wdataAligned,
  output logic [NUM_CH-1:0]              runMask,
  output logic [CNT_W-1:0]               busRdata
);
  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  logic [3:0]       offs;
  logic             startHit, wrEn;
  logic [CNT_W-1:0] word;

  assign grp          = busAddr[ADDR_W-1:4];
  assign offs         = busAddr[3:0];
  assign startHit     = (grp == '0) && (offs == 4'h0);
  assign wrEn         = busSel & busWr;
  assign wdataAligned = busWide ? busWdata
                                : {busWdata[HALF_W-1:0], busWdata[HALF_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runMask <= '0;
    else if (wrEn && startHit) runMask <= busWdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic grpHit;
    assign grpHit = (grp == GRP_W'(g + 1));
    always_comb begin
      strb[g] = '0;
      if (wrEn && grpHit) begin
        case (offs)
          4'h0: strb[g].csrWr = 1'b1;
          4'h4: begin strb[g].cntLo = 1'b1; strb[g].cntHi = busWide; end
          4'h6: strb[g].cntHi = ~busWide;
          4'h8: begin strb[g].cmpLo = 1'b1; strb[g].cmpHi = busWide; end
          4'hA: strb[g].cmpHi = ~busWide;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    word = '0;
    if (startHit) word = CNT_W'(runMask);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (grp == GRP_W'(ch + 1)) begin
        case (offs)
          4'h0: word = CNT_W'(csrRd[ch]);
          4'h4: word = cntRd[ch];
          4'h6: word = CNT_W'(cntRd[ch][CNT_W-1:HALF_W]);
          4'h8: word = cmpRd[ch];
          4'hA: word = CNT_W'(cmpRd[ch][CNT_W-1:HALF_W]);
          default: ;
        endcase
      end
    end
    busRdata = busWide ? word : CNT_W'(word[HALF_W-1:0]);
  end
endmodule

// File: rtl/match_timer.sv
module match_timer import mt_pkg::*; #(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 8,
  parameter int SYNC_REFS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] irq
);
  chanStrb_t [NUM_CH-1:0]         strb;
  logic [NUM_CH-1:0][HALF_W-1:0]  csrRd;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntRd;
  logic [NUM_CH-1:0][CNT_W-1:0]   cmpRd;
  logic [CNT_W-1:0]               wdataAligned;
  logic [NUM_CH-1:0]              runMask;

  mt_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk          (clk),
    .rstN         (rstN),
    .busSel       (busSel),
    .busWr        (busWr),
    .busWide      (busWide),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .csrRd        (csrRd),
    .cntRd        (cntRd),
    .cmpRd        (cmpRd),
    .strb         (strb),
    .wdataAligned (wdataAligned),
    .runMask      (runMask),
    .busRdata     (busRdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mt_chan #(.SYNC_REFS(SYNC_REFS)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .refPulse (refPulse),
      .run      (runMask[g]),
      .strb     (strb[g]),
      .wdata    (wdataAligned),
      .csrRd    (csrRd[g]),
      .cntRd    (cntRd[g]),
      .cmpRd    (cmpRd[g]),
      .irq      (irq[g])
    );
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker import mt_pkg::*; #(
  parameter int NUM_CH = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          refPulse,
  input logic [NUM_CH-1:0]             runMask,
  input logic [NUM_CH-1:0][HALF_W-1:0] csrRd,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntRd,
  input chanStrb_t [NUM_CH-1:0]        strb,
  input logic [NUM_CH-1:0]             irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R9
    hold_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!runMask[g] && !csrRd[g][B_WIP]) |=> $stable(cntRd[g]));
    // R9
    flag_run_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(csrRd[g][B_CMF]) |-> $past(runMask[g]));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(csrRd[g][B_CMF]) |-> $past(strb[g].csrWr));
    // R5
    prd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(csrRd[g][B_CMF]) && $past(csrRd[g][B_PRD])) |-> (cntRd[g] == '0));
    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(csrRd[g][B_OVF]) |-> ((cntRd[g] == '0) && !$past(csrRd[g][B_PRD])));
    // R10
    wip_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(csrRd[g][B_WIP]) |-> $past(refPulse));
    // R4
    irq_type_chk: assert property (@(posedge clk) disable iff (!rstN)
      (csrRd[g][5:4] != REQ_IRQ) |-> !irq[g]);
  end
endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH)) u_mtChk (
  .clk      (clk),
  .rstN     (rstN),
  .refPulse (refPulse),
  .runMask  (runMask),
  .csrRd    (csrRd),
  .cntRd    (cntRd),
  .strb     (strb),
  .irq      (irq)
);

// File: tb/test_match_timer.sv
`timescale 1ns/100ps
module test_match_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refPulse = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic        busWide = 1'b1;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  int pushCnt = 0;
  int popCnt = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  logic [31:0] obsQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .busSel(busSel),
    .busWr(busWr), .busWide(busWide), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d; busWide = w;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busWritePulse(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d; busWide = 1; refPulse = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; refPulse = 0;
  endtask

  task automatic refTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refPulse = 1;
      @(negedge clk); refPulse = 0;
    end
  endtask

  // driver: push the expected item, then the observation
  task automatic expectRead(input logic [7:0] a, input logic w,
                            input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busWide = w; busSel = 1; busWr = 0;
    #1;
    expQ.push_back(e); tagQ.push_back(tag); obsQ.push_back(busRdata);
    pushCnt++;
    busSel = 0; busWide = 1;
  endtask

  task automatic expectIrq(input logic [3:0] e, input string tag);
    @(negedge clk);
    #1;
    expQ.push_back({28'b0, e}); tagQ.push_back(tag); obsQ.push_back({28'b0, irq});
    pushCnt++;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      logic [31:0] got, exp;
      string t;
      wait (pushCnt > popCnt);
      got = obsQ.pop_front(); exp = expQ.pop_front(); t = tagQ.pop_front();
      popCnt++;
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", t, got, exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    expectRead(8'h00, 1, 32'h0, "R1 start reg");
    expectRead(8'h10, 1, 32'h0, "R1 csr0");
    expectRead(8'h14, 1, 32'h0, "R1 cnt0");
    expectRead(8'h48, 1, 32'hFFFFFFFF, "R1 cmp3");
    expectIrq(4'h0, "R1 irq");

    // R10 staged counter write on a stopped channel
    busWrite(8'h14, 32'h5, 1);
    expectRead(8'h10, 1, 32'h2000, "R10 pending bit");
    expectRead(8'h14, 1, 32'h0, "R10 old value");
    refTicks(1);
    expectRead(8'h14, 1, 32'h0, "R10 after one pulse");
    refTicks(1);
    expectRead(8'h14, 1, 32'h5, "R10 applied");
    expectRead(8'h10, 1, 32'h0, "R10 pending cleared");

    // R11 half-word accesses
    busWrite(8'h16, 32'h1234, 0);
    refTicks(2);
    expectRead(8'h14, 1, 32'h12340005, "R11 cnt hi write");
    expectRead(8'h16, 0, 32'h1234, "R11 cnt hi read");
    expectRead(8'h14, 0, 32'h0005, "R11 cnt lo read");
    busWrite(8'h18, 32'h0003, 0);
    expectRead(8'h18, 1, 32'hFFFF0003, "R11 cmp lo write");
    busWrite(8'h1A, 32'h0000, 0);
    expectRead(8'h18, 1, 32'h00000003, "R11 cmp hi write");
    busWrite(8'h14, 32'h0, 1);
    refTicks(2);
    expectRead(8'h14, 1, 32'h0, "R10 clear to zero");

    // R5 periodic, R4 flag and irq, div by 1 (code 7)
    busWrite(8'h10, 32'h0127, 1);
    busWrite(8'h00, 32'h1, 1);
    refTicks(3);
    expectRead(8'h14, 1, 32'h3, "R3 div1 count");
    expectRead(8'h10, 1, 32'h0127, "R4 no flag before match");
    expectIrq(4'h0, "R4 irq low before match");
    refTicks(1);
    expectRead(8'h14, 1, 32'h0, "R5 cleared on match");
    expectRead(8'h10, 1, 32'h8127, "R4 flag set");
    expectIrq(4'h1, "R4 irq high");
    refTicks(3);
    expectRead(8'h14, 1, 32'h3, "R5 second period");
    refTicks(1);
    expectRead(8'h14, 1, 32'h0, "R5 period compare+1");
    busWrite(8'h10, 32'h0127, 1);
    expectRead(8'h10, 1, 32'h0127, "R7 flag cleared");
    expectIrq(4'h0, "R7 irq dropped");
    refTicks(2);

    // R9 stopped channel holds, R3 div 8
    busWrite(8'h20, 32'h0004, 1);
    busWrite(8'h00, 32'h2, 1);
    refTicks(7);
    expectRead(8'h24, 1, 32'h0, "R3 div8 before");
    refTicks(1);
    expectRead(8'h24, 1, 32'h1, "R3 div8 tick");
    expectRead(8'h14, 1, 32'h2, "R9 stopped cnt held");
    expectRead(8'h10, 1, 32'h0127, "R9 stopped no flag");
    refTicks(8);
    expectRead(8'h24, 1, 32'h2, "R3 div8 second");
    expectRead(8'h00, 1, 32'h2, "R2 start readback");

    // R3 div 32 and 128, R2 two channels running
    busWrite(8'h30, 32'h0005, 1);
    busWrite(8'h00, 32'h6, 1);
    refTicks(31);
    expectRead(8'h34, 1, 32'h0, "R3 div32 before");
    refTicks(1);
    expectRead(8'h34, 1, 32'h1, "R3 div32 tick");
    expectRead(8'h24, 1, 32'h6, "R2 ch1 alongside");
    busWrite(8'h30, 32'h0006, 1);
    refTicks(127);
    expectRead(8'h34, 1, 32'h1, "R3 div128 before");
    refTicks(1);
    expectRead(8'h34, 1, 32'h2, "R3 div128 tick");
    expectRead(8'h24, 1, 32'h16, "R2 ch1 count");

    // R6 overflow, code 0 counts every pulse
    busWrite(8'h00, 32'h8, 1);
    busWrite(8'h40, 32'h0020, 1);
    busWrite(8'h44, 32'hFFFFFFFD, 1);
    refTicks(2);
    expectRead(8'h44, 1, 32'hFFFFFFFD, "R10 applied while running");
    refTicks(2);
    expectRead(8'h44, 1, 32'hFFFFFFFF, "R3 code0 div1");
    expectRead(8'h40, 1, 32'h0020, "R6 no flags yet");
    refTicks(1);
    expectRead(8'h44, 1, 32'h0, "R6 wrapped");
    expectRead(8'h40, 1, 32'hC020, "R6 overflow and match");
    expectIrq(4'h8, "R4 irq ch3");
    refTicks(1);
    expectRead(8'h44, 1, 32'h1, "R6 keeps running");
    expectRead(8'h24, 1, 32'h16, "R9 ch1 held");

    // R7 write-one keeps, other bits take value, R12
    busWrite(8'h40, 32'h8020, 1);
    expectRead(8'h40, 1, 32'h8020, "R7 keep cmf clear ovf");
    busWrite(8'h40, 32'h82A0, 1);
    expectRead(8'h40, 1, 32'h82A0, "R7 plain bits");
    busWrite(8'h40, 32'h0, 1);
    expectRead(8'h40, 1, 32'h0, "R12 csr zero");
    expectIrq(4'h0, "R12 irq off");

    // R8 set wins over clear in the same cycle
    busWrite(8'h48, 32'h0, 1);
    busWrite(8'h40, 32'h0127, 1);
    busWrite(8'h44, 32'h0, 1);
    refTicks(2);
    refTicks(1);
    expectRead(8'h40, 1, 32'h8127, "R8 flag set");
    busWrite(8'h40, 32'h0127, 1);
    expectRead(8'h40, 1, 32'h0127, "R8 clear alone");
    busWritePulse(8'h40, 32'h0127);
    expectRead(8'h40, 1, 32'h8127, "R8 set beats clear");
    expectIrq(4'h8, "R8 irq kept");

    // R2 unused start bits
    busWrite(8'h00, 32'hFFFF, 1);
    expectRead(8'h00, 1, 32'hF, "R2 upper bits zero");

    wait (popCnt == pushCnt);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule